// File: doc/BRIEF.md
# Descriptor-Chain DMA Sequencer

This block is the control sequencer of a DMA engine that walks a linked chain of descriptors in system memory and moves data between that memory and a card data FIFO. Software places a chain of two-word descriptors in memory, points the block at the first one and pulses a start input. The sequencer then repeats one cycle of work per descriptor. It fetches the descriptor and checks that the engine owns it. It runs fixed-size bursts in the direction the descriptor names. It then hands the descriptor back by writing word 0 with the ownership flag cleared. After that it follows the next pointer, or stops at a descriptor marked last.

Three kinds of event leave the block as single-cycle pulses: a descriptor finished in the transmit or receive direction, a descriptor found without ownership, and a fatal bus error. The present state is driven out as a fixed 4-bit code that software can read. A descriptor without ownership parks the engine in a suspend state until software resumes it. A bus error stops the engine completely and holds a direction-tagged abort code. The engine stays stopped until software clears that code. A simple request, grant and done handshake stands in for the real bus master. Each bus transaction is held on `req_o` until it is granted and is complete on the first `done_i` after the grant.

Top module: `dmac_ctrl_fsm`

## Requirements
- R1: `state_o` carries one of nine codes and nothing else: 0 idle, 1 suspend, 2 descriptor fetch, 3 descriptor check, 4 memory-read request wait, 5 memory-write request wait, 6 memory read burst, 7 memory write burst, 8 descriptor close.
- R2: In idle the engine leaves only on a `start_i` pulse while no abort code is held. It then fetches word 0 from `desc_base_i` and word 1 from `desc_base_i`+4, and `state_o` shows 2 in the cycle after the pulse.
- R3: If bit 31 (ownership) of word 0 is 0, the engine pulses `desc_unavail_o`, enters suspend and waits there until a `resume_i` pulse. It then fetches the same descriptor again.
- R4: Bit 29 of word 0 selects the direction. With 1 (transmit), the bursts are memory reads (states 4 and 6) and `tx_done_o` pulses once. With 0 (receive), the bursts are memory writes (states 5 and 7) and `rx_done_o` pulses once. The pulse coincides with entry into close.
- R5: Word 1 bits [15:0] give the byte count and bits [31:16] give the buffer address. The engine runs ceil(count / 16) bursts, advancing the address by 16 each time. A count of 0 runs no burst and raises no done pulse.
- R6: In close, the engine writes word 0 back to the descriptor address with bit 31 cleared. If bit 30 (last) is set, it returns to idle. Otherwise it fetches next from the address in word 0 bits [15:0].
- R7: `err_i` with `done_i` on any granted transaction pulses `fatal_o` and returns the engine to idle. It also sets `abort_code_o` to 3'b001 if the current descriptor is transmit, or 3'b010 if it is receive. While that code is held, `req_o` stays low and `start_i` is ignored.
- R8: An `err_clr_i` pulse clears `abort_code_o` to 0, and a later `start_i` runs normally.
- R9: In states 4 or 5, `resp_err_i` with `ces_en_i` high skips all remaining bursts and goes to close without a done pulse. With `ces_en_i` low, `resp_err_i` has no effect.
- R10: After reset, `state_o` is 0, `req_o` is low, `abort_code_o` is 0 and no event output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse from software |
| resume_i | input | 1 | Resume pulse that leaves suspend |
| err_clr_i | input | 1 | Clears the held abort code |
| desc_base_i | input | ADDR_W | Address of the first descriptor |
| ces_en_i | input | 1 | Enables abort on a card response error |
| resp_err_i | input | 1 | Card response error indication |
| req_o | output | 1 | Bus transaction request, held until granted |
| we_o | output | 1 | 1 = memory write, 0 = memory read |
| addr_o | output | ADDR_W | Transaction address |
| wdata_o | output | 32 | Write-back data in close |
| gnt_i | input | 1 | Request accepted |
| done_i | input | 1 | Granted transaction complete |
| err_i | input | 1 | Bus error, valid with done_i |
| rdata_i | input | 32 | Read data, valid with done_i |
| state_o | output | 4 | Present state code |
| tx_done_o | output | 1 | Transmit descriptor finished pulse |
| rx_done_o | output | 1 | Receive descriptor finished pulse |
| desc_unavail_o | output | 1 | Descriptor not owned pulse |
| fatal_o | output | 1 | Fatal bus error pulse |
| abort_code_o | output | 3 | Held abort code |

## Verification
Every state change and every event pulse is registered, so each one appears one clock after the edge that samples the triggering `start_i`, `resume_i`, `done_i` or `resp_err_i`. `req_o`, `addr_o` and `we_o` follow the state in the same cycle. The bench drives every input on the falling edge and samples on the falling edge. It answers a request with a grant on the next falling edge and with done on the one after that. Event pulses and bursts are counted on falling edges, where each one-cycle pulse is seen exactly once. Checks compare the counts before and after a run with values taken from the requirements.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_SUSP  = 4'd1,
    ST_DRD   = 4'd2,
    ST_DCHK  = 4'd3,
    ST_RWAIT = 4'd4,
    ST_WWAIT = 4'd5,
    ST_RD    = 4'd6,
    ST_WR    = 4'd7,
    ST_CLOSE = 4'd8
  } dma_st_e;

  localparam int OWN_BIT  = 31;
  localparam int LAST_BIT = 30;
  localparam int DIR_BIT  = 29;

  localparam logic [2:0] ABT_TX = 3'b001;
  localparam logic [2:0] ABT_RX = 3'b010;
endpackage

// File: rtl/dmac_desc_store.sv
module dmac_desc_store #(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 16,
  parameter int BURST_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_base_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              ld_w0_i,
  input  logic              ld_w1_i,
  input  logic              adv_i,
  input  logic              follow_i,
  input  logic [31:0]       rdata_i,
  output logic [ADDR_W-1:0] cur_ptr_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [31:0]       w0_o,
  output logic              own_o,
  output logic              last_o,
  output logic              dir_o,
  output logic              cnt_zero_o,
  output logic              last_burst_o
);
  import dmac_pkg::*;

  localparam logic [CNT_W-1:0]  BURST_C = CNT_W'(BURST_BYTES);
  localparam logic [ADDR_W-1:0] BURST_A = ADDR_W'(BURST_BYTES);

  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_ptr_o  <= '0;
      buf_addr_o <= '0;
      w0_o       <= '0;
      rem_q      <= '0;
    end else begin
      if (ld_base_i)     cur_ptr_o <= base_i;
      else if (follow_i) cur_ptr_o <= w0_o[ADDR_W-1:0];
      if (ld_w0_i) w0_o <= rdata_i;
      if (ld_w1_i) begin
        rem_q      <= rdata_i[CNT_W-1:0];
        buf_addr_o <= rdata_i[CNT_W +: ADDR_W];
      end else if (adv_i) begin
        rem_q      <= rem_q - BURST_C;
        buf_addr_o <= buf_addr_o + BURST_A;
      end
    end
  end

  assign own_o        = w0_o[OWN_BIT];
  assign last_o       = w0_o[LAST_BIT];
  assign dir_o        = w0_o[DIR_BIT];
  assign cnt_zero_o   = (rem_q == '0);
  assign last_burst_o = (rem_q <= BURST_C);
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       resume_i,
  input  logic       err_clr_i,
  input  logic       ces_en_i,
  input  logic       resp_err_i,
  input  logic       gnt_i,
  input  logic       done_i,
  input  logic       err_i,
  input  logic       own_i,
  input  logic       last_i,
  input  logic       dir_i,
  input  logic       cnt_zero_i,
  input  logic       last_burst_i,
  output dma_st_e    st_o,
  output logic       pend_o,
  output logic       idx_o,
  output logic       ld_base_o,
  output logic       ld_w0_o,
  output logic       ld_w1_o,
  output logic       adv_o,
  output logic       follow_o,
  output logic       tx_done_o,
  output logic       rx_done_o,
  output logic       du_o,
  output logic       fatal_o,
  output logic [2:0] code_o
);
  dma_st_e    st_n;
  logic       pend_n, idx_n, tx_n, rx_n, du_n, fat_n;
  logic [2:0] code_n;

  always_comb begin
    st_n = st_o; pend_n = pend_o; idx_n = idx_o; code_n = code_o;
    tx_n = 1'b0; rx_n = 1'b0; du_n = 1'b0; fat_n = 1'b0;
    ld_base_o = 1'b0; ld_w0_o = 1'b0; ld_w1_o = 1'b0;
    adv_o = 1'b0; follow_o = 1'b0;
    if (err_clr_i) code_n = '0;
    case (st_o)
      ST_IDLE:
        if (start_i && code_o == '0) begin
          st_n = ST_DRD; idx_n = 1'b0; pend_n = 1'b0; ld_base_o = 1'b1;
        end
      ST_SUSP:
        if (resume_i) begin
          st_n = ST_DRD; idx_n = 1'b0; pend_n = 1'b0;
        end
      ST_DRD:
        if (!pend_o) begin
          if (gnt_i) pend_n = 1'b1;
        end else if (done_i) begin
          pend_n = 1'b0;
          if (err_i)       fat_n = 1'b1;
          else if (!idx_o) begin ld_w0_o = 1'b1; idx_n = 1'b1; end
          else begin ld_w1_o = 1'b1; st_n = ST_DCHK; end
        end
      ST_DCHK:
        if (!own_i)          begin du_n = 1'b1; st_n = ST_SUSP; end
        else if (cnt_zero_i) st_n = ST_CLOSE;
        else if (dir_i)      st_n = ST_RWAIT;
        else                 st_n = ST_WWAIT;
      ST_RWAIT, ST_WWAIT:
        if (ces_en_i && resp_err_i) st_n = ST_CLOSE;  // abort data phase
        else if (gnt_i)             st_n = (st_o == ST_RWAIT) ? ST_RD : ST_WR;
      ST_RD, ST_WR:
        if (done_i) begin
          if (err_i) fat_n = 1'b1;
          else if (last_burst_i) begin
            st_n = ST_CLOSE;
            if (st_o == ST_RD) tx_n = 1'b1; else rx_n = 1'b1;
          end else begin
            adv_o = 1'b1;
            st_n  = (st_o == ST_RD) ? ST_RWAIT : ST_WWAIT;
          end
        end
      ST_CLOSE:
        if (!pend_o) begin
          if (gnt_i) pend_n = 1'b1;
        end else if (done_i) begin
          pend_n = 1'b0;
          if (err_i)       fat_n = 1'b1;
          else if (last_i) st_n = ST_IDLE;
          else begin follow_o = 1'b1; idx_n = 1'b0; st_n = ST_DRD; end
        end
      default: st_n = ST_IDLE;
    endcase
    if (fat_n) begin
      st_n   = ST_IDLE;
      pend_n = 1'b0;
      code_n = dir_i ? ABT_TX : ABT_RX;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o <= ST_IDLE; pend_o <= 1'b0; idx_o <= 1'b0; code_o <= '0;
      tx_done_o <= 1'b0; rx_done_o <= 1'b0; du_o <= 1'b0; fatal_o <= 1'b0;
    end else begin
      st_o <= st_n; pend_o <= pend_n; idx_o <= idx_n; code_o <= code_n;
      tx_done_o <= tx_n; rx_done_o <= rx_n; du_o <= du_n; fatal_o <= fat_n;
    end
  end
endmodule

// File: rtl/dmac_ctrl_fsm.sv
module dmac_ctrl_fsm #(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 16,
  parameter int BURST_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              resume_i,
  input  logic              err_clr_i,
  input  logic [ADDR_W-1:0] desc_base_i,
  input  logic              ces_en_i,
  input  logic              resp_err_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [31:0]       wdata_o,
  input  logic              gnt_i,
  input  logic              done_i,
  input  logic              err_i,
  input  logic [31:0]       rdata_i,
  output logic [3:0]        state_o,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic              desc_unavail_o,
  output logic              fatal_o,
  output logic [2:0]        abort_code_o
);
  import dmac_pkg::*;

  localparam logic [ADDR_W-1:0] W1_OFS = ADDR_W'(4);

  dma_st_e           st;
  logic              pend, idx;
  logic              ld_base, ld_w0, ld_w1, adv, follow;
  logic              own, last, dir, cnt_zero, last_burst;
  logic [ADDR_W-1:0] cur_ptr, buf_addr;
  logic [31:0]       w0;

  dmac_desc_store #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_BYTES(BURST_BYTES)
  ) u_store (
    .clk_i, .rst_ni,
    .ld_base_i(ld_base), .base_i(desc_base_i),
    .ld_w0_i(ld_w0), .ld_w1_i(ld_w1), .adv_i(adv), .follow_i(follow),
    .rdata_i,
    .cur_ptr_o(cur_ptr), .buf_addr_o(buf_addr), .w0_o(w0),
    .own_o(own), .last_o(last), .dir_o(dir),
    .cnt_zero_o(cnt_zero), .last_burst_o(last_burst)
  );

  dmac_seq u_seq (
    .clk_i, .rst_ni, .start_i, .resume_i, .err_clr_i, .ces_en_i, .resp_err_i,
    .gnt_i, .done_i, .err_i,
    .own_i(own), .last_i(last), .dir_i(dir),
    .cnt_zero_i(cnt_zero), .last_burst_i(last_burst),
    .st_o(st), .pend_o(pend), .idx_o(idx),
    .ld_base_o(ld_base), .ld_w0_o(ld_w0), .ld_w1_o(ld_w1),
    .adv_o(adv), .follow_o(follow),
    .tx_done_o, .rx_done_o, .du_o(desc_unavail_o), .fatal_o,
    .code_o(abort_code_o)
  );

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    case (st)
      ST_DRD: begin
        req_o  = !pend;
        addr_o = idx ? cur_ptr + W1_OFS : cur_ptr;
      end
      ST_RWAIT: begin
        req_o  = 1'b1;
        addr_o = buf_addr;
      end
      ST_WWAIT: begin
        req_o  = 1'b1;
        we_o   = 1'b1;
        addr_o = buf_addr;
      end
      ST_CLOSE: begin
        req_o   = !pend;
        we_o    = 1'b1;
        addr_o  = cur_ptr;
        wdata_o = w0 & ~(32'd1 << OWN_BIT);
      end
      default: ;
    endcase
  end

  assign state_o = st;
endmodule

// File: rtl/dmac_ctrl_chk.sv
module dmac_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       resume_i,
  input logic       req_o,
  input logic [3:0] state_o,
  input logic       tx_done_o,
  input logic       rx_done_o,
  input logic       desc_unavail_o,
  input logic       fatal_o,
  input logic [2:0] abort_code_o
);
  assert_state_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 4'd8);

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd0 && !start_i) |=> state_o == 4'd0);

  assert_unavail_susp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_unavail_o |-> state_o == 4'd1);

  assert_susp_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd1 && !resume_i) |=> state_o == 4'd1);

  assert_done_at_close_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_o || rx_done_o) |-> state_o == 4'd8);

  assert_events_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_done_o, rx_done_o, desc_unavail_o, fatal_o}));

  assert_fatal_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> (state_o == 4'd0 && (abort_code_o == 3'b001 || abort_code_o == 3'b010)));

  assert_halt_noreq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_code_o != 3'd0) |-> !req_o);
endmodule

bind dmac_ctrl_fsm dmac_ctrl_chk u_chk (.*);

// File: tb/tb_dmac_ctrl_fsm.sv
`timescale 1ns/1ps
module tb_dmac_ctrl_fsm;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, resume_i = 1'b0, err_clr_i = 1'b0;
  logic [15:0] desc_base_i = '0;
  logic        ces_en_i = 1'b0, resp_err_i = 1'b0;
  logic        req_o, we_o;
  logic [15:0] addr_o;
  logic [31:0] wdata_o;
  logic        gnt_i = 1'b0, done_i = 1'b0, err_i = 1'b0;
  logic [31:0] rdata_i = '0;
  logic [3:0]  state_o;
  logic        tx_done_o, rx_done_o, desc_unavail_o, fatal_o;
  logic [2:0]  abort_code_o;

  always #4 clk_i = ~clk_i;

  dmac_ctrl_fsm dut (.*);

  int checks = 0, failures = 0;
  logic [31:0] mem [64];
  logic [31:0] wb  [64];
  logic        inj = 1'b0;
  int ph = 0, n_tx = 0, n_rx = 0, n_du = 0, n_fat = 0, n_burst = 0, n_wr = 0;
  logic [15:0] a_q;
  logic        we_q;
  logic [31:0] wd_q;

  // bus responder: grant one falling edge after req, done one later
  always @(negedge clk_i) begin
    if (tx_done_o) n_tx <= n_tx + 1;
    if (rx_done_o) n_rx <= n_rx + 1;
    if (desc_unavail_o) n_du <= n_du + 1;
    if (fatal_o) n_fat <= n_fat + 1;
    case (ph)
      0: if (req_o) begin
           gnt_i <= 1'b1; ph <= 1; a_q <= addr_o; we_q <= we_o; wd_q <= wdata_o;
         end
      1: begin
           gnt_i  <= 1'b0; done_i <= 1'b1;
           rdata_i <= (a_q < 16'h100) ? mem[a_q[7:2]] : 32'd0;
           err_i  <= inj && (a_q >= 16'h100);
           if (we_q && a_q < 16'h100) begin wb[a_q[7:2]] <= wd_q; n_wr <= n_wr + 1; end
           if (a_q >= 16'h100 && (state_o == 4'd6 || state_o == 4'd7)) n_burst <= n_burst + 1;
           ph <= 2;
         end
      default: begin done_i <= 1'b0; err_i <= 1'b0; ph <= 0; end
    endcase
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input bit own, input bit last, input bit dir,
                          input int nxt, input int cnt, input int bufa);
    mem[a >> 2]       = {own, last, dir, 13'd0, nxt[15:0]};
    mem[(a >> 2) + 1] = {bufa[15:0], cnt[15:0]};
  endtask

  task automatic pulse_start(input int base);
    @(negedge clk_i); desc_base_i = base[15:0]; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic wait_rest();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      if (state_o == 4'd0 || state_o == 4'd1) break;
    end
    repeat (3) @(negedge clk_i);
  endtask

  typedef struct packed {
    logic       own; logic last; logic dir; logic [15:0] cnt;
    logic [2:0] bursts; logic tx; logic rx; logic du; logic [3:0] fin;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b1, 1'b1, 16'd16, 3'd1, 1'b1, 1'b0, 1'b0, 4'd0},
    '{1'b1, 1'b1, 1'b0, 16'd40, 3'd3, 1'b0, 1'b1, 1'b0, 4'd0},
    '{1'b1, 1'b1, 1'b1, 16'd0,  3'd0, 1'b0, 1'b0, 1'b0, 4'd0},
    '{1'b1, 1'b1, 1'b1, 16'd17, 3'd2, 1'b1, 1'b0, 1'b0, 4'd0},
    '{1'b1, 1'b1, 1'b0, 16'd1,  3'd1, 1'b0, 1'b1, 1'b0, 4'd0},
    '{1'b0, 1'b1, 1'b1, 16'd16, 3'd0, 1'b0, 1'b0, 1'b1, 4'd1}
  };

  initial begin
    #(8 * 150000);
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures + 1);
    $finish;
  end

  initial begin
    int t0, r0, d0, b0, w0c, f0, nreq;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(state_o == 4'd0, "R10 state", state_o, 0);
    chk(!req_o && abort_code_o == 3'd0, "R10 req/code", {req_o, abort_code_o}, 0);
    chk({tx_done_o, rx_done_o, desc_unavail_o, fatal_o} == 4'd0, "R10 events",
        {tx_done_o, rx_done_o, desc_unavail_o, fatal_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // table walk: one single-descriptor chain per entry (R1 R3 R4 R5 R6)
    for (int v = 0; v < 6; v++) begin
      int da;
      da = 'h80 + 8 * v;
      put_desc(da, VEC[v].own, VEC[v].last, VEC[v].dir, 0, int'(VEC[v].cnt), 'h100);
      t0 = n_tx; r0 = n_rx; d0 = n_du; b0 = n_burst; w0c = n_wr;
      pulse_start(da);
      chk(state_o == 4'd2, "R2 fetch state after start", state_o, 2);
      wait_rest();
      chk(state_o == VEC[v].fin, "R1 final state", state_o, VEC[v].fin);
      chk(n_tx - t0 == int'(VEC[v].tx), "R4 tx_done count", n_tx - t0, VEC[v].tx);
      chk(n_rx - r0 == int'(VEC[v].rx), "R4 rx_done count", n_rx - r0, VEC[v].rx);
      chk(n_du - d0 == int'(VEC[v].du), "R3 unavail count", n_du - d0, VEC[v].du);
      chk(n_burst - b0 == int'(VEC[v].bursts), "R5 burst count", n_burst - b0, VEC[v].bursts);
      if (VEC[v].own) begin
        chk(wb[da >> 2] == (mem[da >> 2] & 32'h7fff_ffff), "R6 write-back own cleared",
            wb[da >> 2], mem[da >> 2] & 32'h7fff_ffff);
        chk(n_wr - w0c == 1, "R6 one write-back", n_wr - w0c, 1);
      end else
        chk(n_wr - w0c == 0, "R3 no write-back when unowned", n_wr - w0c, 0);
    end

    // R3 start ignored in suspend, resume refetches the same descriptor
    pulse_start('h10);
    repeat (3) @(negedge clk_i);
    chk(state_o == 4'd1, "R3 start ignored in suspend", state_o, 1);
    mem[('h80 + 40) >> 2][31] = 1'b1;
    t0 = n_tx;
    @(negedge clk_i); resume_i = 1'b1; @(negedge clk_i); resume_i = 1'b0;
    chk(state_o == 4'd2, "R3 resume to fetch", state_o, 2);
    wait_rest();
    chk(state_o == 4'd0 && n_tx - t0 == 1, "R3 resumed descriptor completes", n_tx - t0, 1);

    // R6 two-descriptor chain via next pointer, tx then rx
    put_desc('h10, 1, 0, 1, 'h20, 32, 'h100);
    put_desc('h20, 1, 1, 0, 0, 16, 'h200);
    t0 = n_tx; r0 = n_rx; b0 = n_burst; w0c = n_wr;
    pulse_start('h10);
    wait_rest();
    chk(n_tx - t0 == 1 && n_rx - r0 == 1, "R6 chain done pulses", n_tx - t0 + n_rx - r0, 2);
    chk(n_burst - b0 == 3, "R5 chain bursts", n_burst - b0, 3);
    chk(n_wr - w0c == 2, "R6 chain write-backs", n_wr - w0c, 2);
    chk(wb['h20 >> 2] == (mem['h20 >> 2] & 32'h7fff_ffff), "R6 second desc closed",
        wb['h20 >> 2], mem['h20 >> 2] & 32'h7fff_ffff);

    // R7 fatal on transmit burst
    put_desc('h30, 1, 1, 1, 0, 48, 'h100);
    inj = 1'b1; t0 = n_tx; f0 = n_fat;
    pulse_start('h30);
    wait_rest();
    chk(n_fat - f0 == 1, "R7 fatal pulse", n_fat - f0, 1);
    chk(abort_code_o == 3'b001, "R7 tx abort code", abort_code_o, 1);
    chk(state_o == 4'd0 && n_tx == t0, "R7 halted without done", state_o, 0);
    pulse_start('h30);
    nreq = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk_i); if (req_o) nreq++; end
    chk(nreq == 0 && state_o == 4'd0, "R7 start ignored, no requests", nreq, 0);
    inj = 1'b0;
    @(negedge clk_i); err_clr_i = 1'b1; @(negedge clk_i); err_clr_i = 1'b0;
    chk(abort_code_o == 3'd0, "R8 code cleared", abort_code_o, 0);

    // R7 fatal on receive burst, then R8 restart works
    put_desc('h38, 1, 1, 0, 0, 16, 'h100);
    inj = 1'b1;
    pulse_start('h38);
    wait_rest();
    chk(abort_code_o == 3'b010, "R7 rx abort code", abort_code_o, 2);
    inj = 1'b0;
    @(negedge clk_i); err_clr_i = 1'b1; @(negedge clk_i); err_clr_i = 1'b0;
    put_desc('h38, 1, 1, 0, 0, 16, 'h100);
    r0 = n_rx;
    pulse_start('h38);
    wait_rest();
    chk(n_rx - r0 == 1 && abort_code_o == 3'd0, "R8 restart after clear", n_rx - r0, 1);

    // R9 response error with enable: skip data, close without done
    put_desc('h40, 1, 1, 1, 0, 48, 'h100);
    ces_en_i = 1'b1; resp_err_i = 1'b1;
    t0 = n_tx; b0 = n_burst; w0c = n_wr;
    pulse_start('h40);
    wait_rest();
    chk(n_tx == t0 && n_burst == b0, "R9 aborted, no bursts or done", n_burst - b0, 0);
    chk(state_o == 4'd0 && n_wr - w0c == 1, "R9 descriptor still closed", n_wr - w0c, 1);
    // R9 without enable: response error ignored
    put_desc('h48, 1, 1, 1, 0, 48, 'h100);
    ces_en_i = 1'b0;
    t0 = n_tx; b0 = n_burst;
    pulse_start('h48);
    wait_rest();
    chk(n_tx - t0 == 1 && n_burst - b0 == 3, "R9 ignored when disabled", n_burst - b0, 3);
    resp_err_i = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule